// File: doc/BRIEF.md
# Receive Frame Packing Buffer

This block is the receive side of a small Ethernet MAC. Incoming frames arrive as a byte stream with a start strobe and an end strobe. Each frame that is accepted goes into one shared byte buffer, wrapped in a fixed layout: a constant tag word, a length and status word, the payload stretched to the Ethernet minimum of 60 bytes, a CRC-32 that the block computes itself, and zero bytes that bring the record to a 4-byte boundary. A host drains the buffer one 32-bit word at a time through a read strobe. A pending-frame counter tells the host how many complete records are waiting.

The block follows the host's position inside the current record. The second word of each record tells the block how many body words follow, so it knows where the record ends and when to lower the pending count. The host can flush the whole buffer by writing zero to the counter. The block decides whether to admit a frame at its start strobe. It assembles the record with one byte or word write per cycle and holds `busy` high until the record is committed.

Top module: `rx_frame_packer`

## Requirements
- R1: A frame is admitted only if `rxEn` is 1 and at least MIN_FREE (1532) bytes of the DEPTH_BYTES (2048) buffer are unread at its start strobe. A frame that is not admitted leaves no trace: `frameCount` stays unchanged and later records read back intact.
- R2: The first word of a record reads as 32'h5AC30F96. The second word carries the padded payload length plus 4 in bits 15:0, has bit 16 set as the good-status flag, and has all other bits zero.
- R3: A payload shorter than 60 bytes is followed by zero bytes up to 60. The stored length and the CRC both count these zero bytes.
- R4: Four CRC bytes follow the padded payload, least significant byte first, then zero bytes up to a multiple of 4. The CRC is the reflected 0x04C11DB7 CRC-32, starts from all ones and has no final inversion. Every word packs its bytes with the earliest byte in bits 7:0.
- R5: Each committed frame raises `frameCount` by one and sets `rxIrq`. A pulse on `rxIrqClr` clears `rxIrq`. `frameCount` is 0 after reset.
- R6: In every record, after the second word the block expects its bits 15:0, rounded up to a multiple of 4, divided by 4 further words. `frameCount` falls by one in the cycle after the last of these words is read, and the next read returns the next record's tag word.
- R7: While `frameCount` is 0, `rdData` is 0 and a read strobe does not consume buffer contents.
- R8: Writing 0 through `cntWr` empties the buffer and resets `frameCount` and the read position. Any frame still being assembled is abandoned. Writing a nonzero value changes nothing.
- R9: A frame whose end strobe comes before any byte is discarded.
- R10: A frame longer than MAX_LEN (1518) bytes is discarded and its space is released. A 1518-byte frame is kept.
- R11: `busy` is high from an admitted start strobe until that record is committed or discarded. The source raises no start strobe while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxEn | input | 1 | Receive enable, sampled at a start strobe |
| frameStart | input | 1 | One-cycle start-of-frame strobe, carries no byte |
| byteValid | input | 1 | `byteData` holds a payload byte this cycle |
| byteData | input | 8 | Payload byte |
| frameEnd | input | 1 | One-cycle end-of-frame strobe, carries no byte |
| rdReq | input | 1 | Host reads one word this cycle |
| rdData | output | 32 | Word at the host read position, 0 when nothing is pending |
| cntWr | input | 1 | Write strobe for the pending-frame counter |
| cntWrData | input | 16 | Value written with `cntWr`; only 0 has an effect |
| frameCount | output | 16 | Number of complete records waiting |
| rxIrq | output | 1 | Receive status flag |
| rxIrqClr | input | 1 | Clears `rxIrq` |
| busy | output | 1 | A record is being assembled |

## Verification
The assertions assume a well-behaved source: start, byte and end strobes never share a cycle, and no start strobe arrives while `busy` is high. The bench meets this by sending each frame in a fixed sequence and waiting for `busy` to drop before the next start strobe. The assertions also assume the host reads only whole records or flushes them. The bench reads each record to its final word, and only the flush test leaves a record half read.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  localparam logic [31:0] TAG_WORD = 32'h5AC3_0F96;
  localparam int GOOD_BIT = 16;

  typedef enum logic [1:0] {SRC_IN, SRC_ZERO, SRC_CRC} byteSrc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_DROP, ST_PAD, ST_CRC, ST_ALIGN, ST_TAG, ST_HDR
  } wrState_e;

  typedef enum logic [1:0] {POS_TAG, POS_HDR, POS_BODY} rdPos_e;

  typedef struct packed {
    logic     byteWr;
    logic     wordWr;
    logic     wordIsHdr;
    byteSrc_e src;
    logic     crcClr;
    logic     crcEn;
  } strobe_t;

endpackage

// File: rtl/rxpk_datapath.sv
module rxpk_datapath
  import rxpk_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  strobe_t                         stb,
  input  logic [$clog2(DEPTH_BYTES)-1:0]  wrAddr,
  input  logic [7:0]                      inByte,
  input  logic [1:0]                      crcIdx,
  input  logic [15:0]                     hdrLen,
  input  logic [$clog2(DEPTH_BYTES)-1:0]  rdAddr,
  input  logic                            rdGate,
  output logic [31:0]                     rdData
);
  localparam int AW    = $clog2(DEPTH_BYTES);
  localparam int WORDS = DEPTH_BYTES / 4;

  logic [31:0] mem [WORDS];
  logic [31:0] crcReg;
  logic [7:0]  wrByte;
  logic [31:0] wrWord;

  function automatic logic [31:0] crcStep(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'b0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  always_comb begin
    case (stb.src)
      SRC_IN:  wrByte = inByte;
      SRC_CRC: wrByte = 8'(crcReg >> {crcIdx, 3'b000});
      default: wrByte = 8'h00;
    endcase
    wrWord = stb.wordIsHdr ? (32'(hdrLen) | (32'd1 << GOOD_BIT)) : TAG_WORD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crcReg <= '1;
    else if (stb.crcClr) crcReg <= '1;
    else if (stb.crcEn)  crcReg <= crcStep(crcReg, wrByte);
  end

  always_ff @(posedge clk) begin
    if (stb.wordWr)      mem[wrAddr[AW-1:2]] <= wrWord;
    else if (stb.byteWr) mem[wrAddr[AW-1:2]][{wrAddr[1:0], 3'b000} +: 8] <= wrByte;
  end

  assign rdData = rdGate ? mem[rdAddr[AW-1:2]] : 32'd0;

endmodule

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048,
  parameter int MIN_FREE    = 1532,
  parameter int MAX_LEN     = 1518,
  parameter int MIN_LEN     = 60
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rxEn,
  input  logic                            frameStart,
  input  logic                            byteValid,
  input  logic                            frameEnd,
  input  logic                            rdReq,
  input  logic [15:0]                     rdLow,
  input  logic                            cntWr,
  input  logic [15:0]                     cntWrData,
  input  logic                            rxIrqClr,
  output strobe_t                         stb,
  output logic [$clog2(DEPTH_BYTES)-1:0]  wrAddr,
  output logic [1:0]                      crcIdx,
  output logic [15:0]                     hdrLen,
  output logic [$clog2(DEPTH_BYTES)-1:0]  rdAddr,
  output logic                            rdGate,
  output logic [15:0]                     frameCount,
  output logic                            rxIrq,
  output logic                            busy,
  output logic [$clog2(DEPTH_BYTES):0]    wrPtrMon,
  output logic [$clog2(DEPTH_BYTES):0]    rdPtrMon
);
  localparam int AW  = $clog2(DEPTH_BYTES);
  localparam int PW  = AW + 1;
  localparam int PW1 = PW + 1;
  localparam int LW  = $clog2(MAX_LEN + 1);

  wrState_e       state;
  rdPos_e         rdPos;
  logic [PW-1:0]  wrPtr, startPtr, rdPtr, used;
  logic [PW:0]    freeB;
  logic [LW-1:0]  lenCnt;
  logic [15:0]    remain;
  logic           clearNow, acceptNow, commit, rdNow, popDone;

  assign used      = wrPtr - rdPtr;
  assign freeB     = PW1'(DEPTH_BYTES) - {1'b0, used};
  assign clearNow  = cntWr && (cntWrData == 16'd0);
  assign acceptNow = (state == ST_IDLE) && frameStart && rxEn && (freeB >= PW1'(MIN_FREE));
  assign commit    = (state == ST_HDR);
  assign rdNow     = rdReq && (frameCount != 16'd0);
  assign popDone   = rdNow && (rdPos == POS_BODY) && (remain == 16'd4);

  always_comb begin
    stb = '0;
    stb.src = SRC_ZERO;
    case (state)
      ST_IDLE:  stb.crcClr = acceptNow;
      ST_DATA:  if (byteValid && lenCnt != LW'(MAX_LEN)) begin
                  stb.byteWr = 1'b1; stb.src = SRC_IN; stb.crcEn = 1'b1;
                end
      ST_PAD:   begin stb.byteWr = 1'b1; stb.crcEn = 1'b1; end
      ST_CRC:   begin stb.byteWr = 1'b1; stb.src = SRC_CRC; end
      ST_ALIGN: stb.byteWr = 1'b1;
      ST_TAG:   stb.wordWr = 1'b1;
      ST_HDR:   begin stb.wordWr = 1'b1; stb.wordIsHdr = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    case (state)
      ST_TAG:  wrAddr = startPtr[AW-1:0];
      ST_HDR:  wrAddr = AW'(startPtr + PW'(4));
      default: wrAddr = wrPtr[AW-1:0];
    endcase
  end

  assign hdrLen   = 16'(lenCnt) + 16'd4;
  assign rdAddr   = rdPtr[AW-1:0];
  assign rdGate   = (frameCount != 16'd0);
  assign busy     = (state != ST_IDLE);
  assign wrPtrMon = wrPtr;
  assign rdPtrMon = rdPtr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; wrPtr <= '0; startPtr <= '0; rdPtr <= '0;
      lenCnt <= '0; crcIdx <= '0; rdPos <= POS_TAG; remain <= '0;
      frameCount <= '0;
    end else if (clearNow) begin
      state <= ST_IDLE; wrPtr <= '0; startPtr <= '0; rdPtr <= '0;
      rdPos <= POS_TAG; remain <= '0; frameCount <= '0;
    end else begin
      case (state)
        ST_IDLE: if (acceptNow) begin
          state <= ST_DATA; startPtr <= wrPtr; wrPtr <= wrPtr + PW'(8); lenCnt <= '0;
        end
        ST_DATA: if (byteValid) begin
          if (lenCnt == LW'(MAX_LEN)) begin
            state <= ST_DROP; wrPtr <= startPtr;
          end else begin
            wrPtr <= wrPtr + PW'(1); lenCnt <= lenCnt + LW'(1);
          end
        end else if (frameEnd) begin
          crcIdx <= '0;
          if (lenCnt == '0) begin
            state <= ST_IDLE; wrPtr <= startPtr;
          end else if (lenCnt < LW'(MIN_LEN)) state <= ST_PAD;
          else state <= ST_CRC;
        end
        ST_DROP: if (frameEnd) state <= ST_IDLE;
        ST_PAD: begin
          wrPtr <= wrPtr + PW'(1); lenCnt <= lenCnt + LW'(1);
          if (lenCnt == LW'(MIN_LEN - 1)) state <= ST_CRC;
        end
        ST_CRC: begin
          wrPtr <= wrPtr + PW'(1); crcIdx <= crcIdx + 2'd1;
          if (crcIdx == 2'd3) state <= (wrPtr[1:0] == 2'd3) ? ST_TAG : ST_ALIGN;
        end
        ST_ALIGN: begin
          wrPtr <= wrPtr + PW'(1);
          if (wrPtr[1:0] == 2'd3) state <= ST_TAG;
        end
        ST_TAG:  state <= ST_HDR;
        default: state <= ST_IDLE;
      endcase
      if (rdNow) begin
        rdPtr <= rdPtr + PW'(4);
        case (rdPos)
          POS_TAG: rdPos <= POS_HDR;
          POS_HDR: begin
            rdPos <= POS_BODY; remain <= (rdLow + 16'd3) & ~16'd3;
          end
          default: begin
            remain <= remain - 16'd4;
            if (remain == 16'd4) rdPos <= POS_TAG;
          end
        endcase
      end
      frameCount <= frameCount + 16'(commit) - 16'(popDone);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rxIrq <= 1'b0;
    else if (commit)   rxIrq <= 1'b1;
    else if (rxIrqClr) rxIrq <= 1'b0;
  end

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxpk_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048,
  parameter int MIN_FREE    = 1532,
  parameter int MAX_LEN     = 1518,
  parameter int MIN_LEN     = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxEn,
  input  logic        frameStart,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        frameEnd,
  input  logic        rdReq,
  output logic [31:0] rdData,
  input  logic        cntWr,
  input  logic [15:0] cntWrData,
  output logic [15:0] frameCount,
  output logic        rxIrq,
  input  logic        rxIrqClr,
  output logic        busy
);
  localparam int AW = $clog2(DEPTH_BYTES);

  strobe_t       stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [1:0]    crcIdx;
  logic [15:0]   hdrLen;
  logic          rdGate;
  logic [AW:0]   wrPtrMon, rdPtrMon;

  rxpk_ctrl #(
    .DEPTH_BYTES(DEPTH_BYTES), .MIN_FREE(MIN_FREE),
    .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .frameStart(frameStart),
    .byteValid(byteValid), .frameEnd(frameEnd), .rdReq(rdReq),
    .rdLow(rdData[15:0]), .cntWr(cntWr), .cntWrData(cntWrData),
    .rxIrqClr(rxIrqClr), .stb(stb), .wrAddr(wrAddr), .crcIdx(crcIdx),
    .hdrLen(hdrLen), .rdAddr(rdAddr), .rdGate(rdGate),
    .frameCount(frameCount), .rxIrq(rxIrq), .busy(busy),
    .wrPtrMon(wrPtrMon), .rdPtrMon(rdPtrMon)
  );

  rxpk_datapath #(.DEPTH_BYTES(DEPTH_BYTES)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrAddr(wrAddr),
    .inByte(byteData), .crcIdx(crcIdx), .hdrLen(hdrLen),
    .rdAddr(rdAddr), .rdGate(rdGate), .rdData(rdData)
  );

endmodule

// File: rtl/rxpk_checker.sv
module rxpk_checker #(
  parameter int DEPTH_BYTES = 2048
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rxEn,
  input logic                         frameStart,
  input logic                         rdReq,
  input logic                         cntWr,
  input logic [15:0]                  cntWrData,
  input logic [15:0]                  frameCount,
  input logic                         rxIrq,
  input logic                         busy,
  input logic [$clog2(DEPTH_BYTES):0] wrPtr,
  input logic [$clog2(DEPTH_BYTES):0] rdPtr
);
  localparam int PW = $clog2(DEPTH_BYTES) + 1;

  logic          clearNow;
  logic [PW-1:0] usedC;
  assign clearNow = cntWr && (cntWrData == 16'd0);
  assign usedC    = wrPtr - rdPtr;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    usedC <= PW'(DEPTH_BYTES));

  p_disabled_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && !rxEn && !busy && !clearNow) |=> !busy);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clearNow |=> (frameCount == $past(frameCount)) ||
                  (frameCount == $past(frameCount) + 16'd1) ||
                  (frameCount == $past(frameCount) - 16'd1));

  p_irq_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clearNow |=> (frameCount == $past(frameCount) + 16'd1) |-> rxIrq);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && frameCount == 16'd0 && !clearNow) |=> (rdPtr == $past(rdPtr)));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearNow |=> (frameCount == 16'd0) && !busy);

endmodule

bind rx_frame_packer rxpk_checker #(.DEPTH_BYTES(DEPTH_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .frameStart(frameStart),
  .rdReq(rdReq), .cntWr(cntWr), .cntWrData(cntWrData),
  .frameCount(frameCount), .rxIrq(rxIrq), .busy(busy),
  .wrPtr(wrPtrMon), .rdPtr(rdPtrMon)
);

// File: tb/rx_frame_packer_bench.sv
module rx_frame_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxEn = 1'b0, frameStart = 1'b0, byteValid = 1'b0, frameEnd = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic rdReq = 1'b0, cntWr = 1'b0, rxIrqClr = 1'b0;
  logic [15:0] cntWrData = 16'h0;
  logic [31:0] rdData;
  logic [15:0] frameCount;
  logic rxIrq, busy;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] expBytes [0:1599];

  always #5 clk = ~clk;

  rx_frame_packer u_rx_frame_packer (
    .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .frameStart(frameStart),
    .byteValid(byteValid), .byteData(byteData), .frameEnd(frameEnd),
    .rdReq(rdReq), .rdData(rdData), .cntWr(cntWr), .cntWrData(cntWrData),
    .frameCount(frameCount), .rxIrq(rxIrq), .rxIrqClr(rxIrqClr), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(int i, int seed);
    return 8'((seed * 13) + (i * 7) + (i >> 3));
  endfunction

  task automatic sendFrame(input int len, input int seed);
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      byteValid = 1'b1; byteData = pay(i, seed);
      @(negedge clk);
    end
    byteValid = 1'b0; frameEnd = 1'b1;
    @(negedge clk) frameEnd = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic readWord(output logic [31:0] w);
    rdReq = 1'b1;
    #1 w = rdData;
    @(negedge clk) rdReq = 1'b0;
  endtask

  task automatic readFrame(input int len, input int seed);
    int p, total;
    logic [31:0] crc, w, e;
    logic [15:0] cnt0;
    string tag;
    p = (len < 60) ? 60 : len;
    total = ((p + 4 + 3) / 4) * 4;
    tag = (len < 60) ? "R3" : "R4";
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < total; i++) expBytes[i] = 8'h00;
    for (int i = 0; i < p; i++) begin
      expBytes[i] = (i < len) ? pay(i, seed) : 8'h00;
      crc = crc ^ {24'b0, expBytes[i]};
      for (int k = 0; k < 8; k++) crc = crc[0] ? ((crc >> 1) ^ 32'hEDB8_8320) : (crc >> 1);
    end
    for (int k = 0; k < 4; k++) expBytes[p + k] = 8'(crc >> (8 * k));
    cnt0 = frameCount;
    readWord(w); check(w == 32'h5AC3_0F96, "R2 tag word", w, 32'h5AC3_0F96);
    e = 32'h0001_0000 | 32'(p + 4);
    readWord(w); check(w == e, "R2 header word", w, e);
    for (int j = 0; j < total / 4; j++) begin
      if (j == total / 4 - 1) check(frameCount == cnt0, "R6 count held mid-record", 32'(frameCount), 32'(cnt0));
      readWord(w);
      e = {expBytes[4*j+3], expBytes[4*j+2], expBytes[4*j+1], expBytes[4*j]};
      check(w == e, tag, w, e);
    end
    check(frameCount == cnt0 - 16'd1, "R6 count after record", 32'(frameCount), 32'(cnt0 - 16'd1));
  endtask

  task automatic pulseClr(input logic [15:0] v);
    @(negedge clk) begin cntWr = 1'b1; cntWrData = v; end
    @(negedge clk) cntWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(frameCount == 16'd0, "R5 count after reset", 32'(frameCount), 0);
    check(rxIrq == 1'b0, "R5 irq after reset", 32'(rxIrq), 0);
    check(busy == 1'b0, "R11 idle after reset", 32'(busy), 0);
    check(rdData == 32'd0, "R7 data when empty", rdData, 0);
    readWord(w);
    check(w == 32'd0, "R7 read when empty", w, 0);
    rxEn = 1'b1;
    sendFrame(10, 1);
    check(frameCount == 16'd1, "R7 no pop before frame", 32'(frameCount), 1);
    readFrame(10, 1);

    // Length sweep across padding and alignment boundaries
    for (int len = 1; len <= 72; len++) begin
      sendFrame(len, len);
      check(frameCount == 16'd1, "R5 count after accept", 32'(frameCount), 1);
      check(rxIrq == 1'b1, "R5 irq set", 32'(rxIrq), 1);
      @(negedge clk) rxIrqClr = 1'b1;
      @(negedge clk) rxIrqClr = 1'b0;
      check(rxIrq == 1'b0, "R5 irq cleared", 32'(rxIrq), 0);
      readFrame(len, len);
    end

    // Several records queued
    sendFrame(100, 3); sendFrame(20, 4); sendFrame(64, 5);
    check(frameCount == 16'd3, "R5 three queued", 32'(frameCount), 3);
    readFrame(100, 3); readFrame(20, 4); readFrame(64, 5);

    // Empty frame
    sendFrame(0, 0);
    check(frameCount == 16'd0, "R9 empty frame dropped", 32'(frameCount), 0);
    check(busy == 1'b0, "R11 idle after empty", 32'(busy), 0);

    // Length limit
    sendFrame(1518, 6);
    check(frameCount == 16'd1, "R10 max length kept", 32'(frameCount), 1);
    readFrame(1518, 6);
    sendFrame(1519, 7);
    check(frameCount == 16'd0, "R10 overlong dropped", 32'(frameCount), 0);
    sendFrame(33, 8);
    readFrame(33, 8);

    // Receive disabled
    rxEn = 1'b0;
    sendFrame(20, 9);
    check(frameCount == 16'd0, "R1 disabled drop", 32'(frameCount), 0);
    rxEn = 1'b1;

    // Free-space threshold: 504-byte frame uses 516, leaving exactly 1532
    sendFrame(504, 10);
    sendFrame(60, 11);
    check(frameCount == 16'd2, "R1 exact threshold admits", 32'(frameCount), 2);
    sendFrame(10, 12);
    check(frameCount == 16'd2, "R1 short of space drops", 32'(frameCount), 2);
    readFrame(504, 10); readFrame(60, 11);
    sendFrame(505, 13);
    sendFrame(60, 14);
    check(frameCount == 16'd1, "R1 one byte short drops", 32'(frameCount), 1);
    readFrame(505, 13);
    sendFrame(61, 15);
    readFrame(61, 15);

    // Counter writes
    sendFrame(30, 16); sendFrame(40, 17);
    pulseClr(16'd5);
    check(frameCount == 16'd2, "R8 nonzero write ignored", 32'(frameCount), 2);
    readFrame(30, 16);
    pulseClr(16'd0);
    check(frameCount == 16'd0, "R8 flush clears count", 32'(frameCount), 0);
    readWord(w);
    check(w == 32'd0, "R8 flushed buffer reads zero", w, 0);
    sendFrame(40, 18);
    readFrame(40, 18);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule